// File: doc/BRIEF.md
# Per-Thread Deadline Timer Unit

This unit holds a bank of countdown timers for a processor that interleaves its hardware threads one slot at a time in a fixed rotation. Each thread owns two timers. Every issue slot presents the owning thread's number, a flag marking the decoded instruction as a deadline instruction, a timer selector and an immediate. The unit answers, in the same cycle, whether that slot must stall. A stalled slot changes no timer through the deadline path, and the issue logic replays the same PC on the thread's next turn.

A thread's timers count down only while its own slot passes. Because the rotation is strict, each pass subtracts the thread count, which equals one per elapsed clock cycle. A deadline instruction proceeds only once its selected timer has reached zero. It then writes its immediate as the new deadline. Software places a deadline instruction at each end of a code block, and the block then takes a fixed number of cycles no matter how much work lies between the two deadlines.

Top module: `deadline_timer_unit`

## Requirements
- R1: Reset clears every timer to zero. On the first slot of any thread after reset, a deadline instruction does not stall.
- R2: `slotStall` is combinational for the current slot. It is 1 exactly when `slotIsDeadline` is 1 and the selected timer, after this slot's decrement, is nonzero.
- R3: A stalled deadline instruction loads nothing. The selected timer keeps counting down, and the replayed instruction proceeds on the first turn at which that timer has expired.
- R4: A deadline instruction that proceeds writes `slotImm` into the selected timer of its thread.
- R5: Each slot of thread t lowers both of t's timers by N_THREADS (6), saturating at zero and never wrapping. Timers of other threads keep their values.
- R6: `slotTimerSel` picks timer 0 (value 0) or timer 1 (value 1). Loading or counting one of a thread's timers never affects whether a deadline on the other one stalls.
- R7: A deadline instruction with immediate 0 waits for the pending deadline and leaves the timer at zero. The next deadline on that timer then proceeds on its first attempt.
- R8: Take a thread whose successive deadlines on one timer each carry immediate V. Let K be the number of that thread's slots from one accepted deadline to the next deadline on that timer. The accepted deadlines are then 6*max(K, ceil(V/6)) cycles apart, so when the work fits, V a multiple of 6 gives exactly V cycles.
- R9: `slotThread` must advance 0,1,...,N_THREADS-1 and wrap, one step per cycle, from the first slot after reset.
- R10: A slot with `slotIsDeadline` = 0 never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one issue slot per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| slotThread | input | 3 | Thread owning the current slot |
| slotIsDeadline | input | 1 | 1 when the decoded instruction is a deadline instruction |
| slotTimerSel | input | 1 | Which of the thread's two timers the instruction uses |
| slotImm | input | 32 | New deadline value in cycles |
| slotStall | output | 1 | 1 when the slot must be replayed |

## Verification
A timer that holds a wrong value is visible only through `slotStall`. The error shows up the next time that thread issues a deadline on that timer. If the count is too high, the block stretches by one or more rotations. If the count is too low or has wrapped, the deadline either releases early or never releases. The bench therefore predicts the stall of every slot, and it also measures the spacing of accepted deadlines for six threads that run different workloads. A fault is reported within a few rotations of the slot that caused it.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

  // Strobes from the stall decision to the timer bank.
  typedef struct packed {
    logic stall;  // slot must be replayed
    logic load;   // deadline accepted: write immediate
  } dlt_strobe_t;

endpackage

// File: rtl/dlt_sat_dec.sv
module dlt_sat_dec #(
  parameter int unsigned W    = 32,
  parameter int unsigned STEP = 6
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam logic [W-1:0] StepW = W'(STEP);

  always_comb begin
    if (din > StepW) dout = din - StepW;
    else             dout = '0;
  end

endmodule

// File: rtl/dlt_control.sv
module dlt_control
  import dlt_pkg::*;
#(
  parameter int unsigned N_THREADS = 6,
  parameter int unsigned TID_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TID_W-1:0] slotThread,
  input  logic             slotIsDeadline,
  input  logic             selExpired,
  output dlt_strobe_t      strb
);

  localparam logic [TID_W-1:0] LastTid = TID_W'(N_THREADS - 1);

  always_comb begin
    strb.stall = slotIsDeadline && !selExpired;
    strb.load  = slotIsDeadline &&  selExpired;
  end

  // Marks that at least one post-reset slot has been seen.
  logic primedQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primedQ <= 1'b0;
    else       primedQ <= 1'b1;
  end

  AST_RR_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    primedQ |-> slotThread == (($past(slotThread) == LastTid) ? '0 : $past(slotThread) + 1'b1)); // R9

  AST_FIRST_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !primedQ |-> slotThread == '0); // R9

endmodule

// File: rtl/dlt_datapath.sv
module dlt_datapath
  import dlt_pkg::*;
#(
  parameter int unsigned N_THREADS = 6,
  parameter int unsigned TIMERS    = 2,
  parameter int unsigned TIMER_W   = 32,
  parameter int unsigned TID_W     = 3,
  parameter int unsigned SEL_W     = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TID_W-1:0]   slotThread,
  input  logic [SEL_W-1:0]   slotTimerSel,
  input  logic [TIMER_W-1:0] slotImm,
  input  dlt_strobe_t        strb,
  output logic               selExpired
);

  logic [TIMER_W-1:0] timerQ [N_THREADS][TIMERS];
  logic [TIMER_W-1:0] rdVal  [TIMERS];
  logic [TIMER_W-1:0] decVal [TIMERS];
  logic [TIMER_W-1:0] selRaw;
  logic [TIMER_W-1:0] selDec;

  // Read out the issuing thread's timers.
  always_comb begin
    for (int i = 0; i < TIMERS; i++) begin
      rdVal[i] = '0;
      for (int t = 0; t < N_THREADS; t++) begin
        if (slotThread == TID_W'(t)) rdVal[i] = timerQ[t][i];
      end
    end
  end

  // One saturating decrementer per timer index, shared by all threads.
  for (genvar i = 0; i < TIMERS; i++) begin : g_dec
    dlt_sat_dec #(.W(TIMER_W), .STEP(N_THREADS)) u_dec (
      .din  (rdVal[i]),
      .dout (decVal[i])
    );
  end

  always_comb begin
    selRaw = '0;
    selDec = '0;
    for (int i = 0; i < TIMERS; i++) begin
      if (slotTimerSel == SEL_W'(i)) begin
        selRaw = rdVal[i];
        selDec = decVal[i];
      end
    end
  end

  assign selExpired = (selDec == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < N_THREADS; t++)
        for (int i = 0; i < TIMERS; i++)
          timerQ[t][i] <= '0;
    end else begin
      for (int t = 0; t < N_THREADS; t++) begin
        if (slotThread == TID_W'(t)) begin
          for (int i = 0; i < TIMERS; i++) begin
            if (strb.load && slotTimerSel == SEL_W'(i)) timerQ[t][i] <= slotImm;
            else                                      timerQ[t][i] <= decVal[i];
          end
        end
      end
    end
  end

  // Set once a post-reset slot has updated the bank.
  logic liveQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) liveQ <= 1'b0;
    else       liveQ <= 1'b1;
  end

  AST_STALL_NEEDS_TIME: assert property (@(posedge clk) disable iff (!rstN)
    strb.stall |-> selRaw > TIMER_W'(N_THREADS)); // R2

  for (genvar t = 0; t < N_THREADS; t++) begin : g_chk_thr
    for (genvar i = 0; i < TIMERS; i++) begin : g_chk_tmr
      AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && $past(strb.load && slotThread == TID_W'(t) && slotTimerSel == SEL_W'(i)))
        |-> timerQ[t][i] == $past(slotImm)); // R4

      AST_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && timerQ[t][i] > $past(timerQ[t][i]))
        |-> $past(strb.load && slotThread == TID_W'(t) && slotTimerSel == SEL_W'(i))); // R5

      AST_OTHER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && $past(slotThread) != TID_W'(t)) |-> $stable(timerQ[t][i])); // R5
    end
  end

endmodule

// File: rtl/deadline_timer_unit.sv
module deadline_timer_unit
  import dlt_pkg::*;
#(
  parameter int unsigned N_THREADS = 6,
  parameter int unsigned TIMERS    = 2,
  parameter int unsigned TIMER_W   = 32,
  localparam int unsigned TID_W    = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int unsigned SEL_W    = (TIMERS > 1) ? $clog2(TIMERS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TID_W-1:0]   slotThread,
  input  logic               slotIsDeadline,
  input  logic [SEL_W-1:0]   slotTimerSel,
  input  logic [TIMER_W-1:0] slotImm,
  output logic               slotStall
);

  dlt_strobe_t strb;
  logic        selExpired;

  dlt_control #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_control (
    .clk            (clk),
    .rstN           (rstN),
    .slotThread     (slotThread),
    .slotIsDeadline (slotIsDeadline),
    .selExpired     (selExpired),
    .strb           (strb)
  );

  dlt_datapath #(
    .N_THREADS (N_THREADS),
    .TIMERS    (TIMERS),
    .TIMER_W   (TIMER_W),
    .TID_W     (TID_W),
    .SEL_W     (SEL_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .slotThread   (slotThread),
    .slotTimerSel (slotTimerSel),
    .slotImm      (slotImm),
    .strb         (strb),
    .selExpired   (selExpired)
  );

  assign slotStall = strb.stall;

  AST_PLAIN_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    !slotIsDeadline |-> !slotStall); // R10

endmodule

// File: tb/deadline_timer_unit_bench.sv
module deadline_timer_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  slotThread = '0;
  logic        slotIsDeadline = 1'b0;
  logic [0:0]  slotTimerSel = '0;
  logic [31:0] slotImm = '0;
  logic        slotStall;

  deadline_timer_unit u_deadline_timer_unit (
    .clk            (clk),
    .rstN           (rstN),
    .slotThread     (slotThread),
    .slotIsDeadline (slotIsDeadline),
    .slotTimerSel   (slotTimerSel),
    .slotImm        (slotImm),
    .slotStall      (slotStall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Scoreboard queues: expected stall and the requirement it checks.
  bit    expQ[$];
  string tagQ[$];

  // Per-thread program: deadline, then W plain instructions, repeated.
  int unsigned cfgV0[NT] = '{30, 30, 30, 60, 0, 7};
  int unsigned cfgV1[NT] = '{0, 0, 0, 0, 0, 0};
  int unsigned cfgW [NT] = '{2, 7, 4, 1, 3, 0};
  bit          cfgAlt[NT] = '{0, 0, 0, 1, 0, 0};
  bit          cfgSel[NT] = '{0, 1, 0, 0, 1, 0};

  int unsigned mdl[NT][2];
  int          step[NT];
  bit          altPh[NT];
  longint      lastAcc[NT][2];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic int unsigned satDec(input int unsigned x);
    return (x > NT) ? x - NT : 0;
  endfunction

  task automatic resetAll();
    rstN = 1'b0;
    slotThread = 3'd0;
    slotIsDeadline = 1'b1;
    slotTimerSel = 1'b0;
    slotImm = 32'd5;
    for (int t = 0; t < NT; t++) begin
      mdl[t][0] = 0; mdl[t][1] = 0;
      step[t] = 0; altPh[t] = 0;
      lastAcc[t][0] = -1; lastAcc[t][1] = -1;
    end
    @(negedge clk); #1;
    chk(slotStall == 1'b0, "R1 reset state", slotStall, 0);
    slotTimerSel = 1'b1;
    #1;
    chk(slotStall == 1'b0, "R1 reset state timer 1", slotStall, 0);
    repeat (2) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  task automatic runPhase(input int nSlots);
    for (int s = 0; s < nSlots; s++) begin
      int t;
      bit dead, sel, expS, act;
      int unsigned imm, d0, d1, dsel;
      string tag;
      if (s > 0) begin
        @(posedge clk); #1;
      end
      t    = s % NT;  // R9: strict rotation from thread 0
      dead = (step[t] == 0);
      sel  = cfgAlt[t] ? altPh[t] : cfgSel[t];
      imm  = (cfgAlt[t] && sel) ? cfgV1[t] : cfgV0[t];
      slotThread     = 3'(t);
      slotIsDeadline = dead;
      slotTimerSel   = sel;
      slotImm        = imm;

      d0   = satDec(mdl[t][0]);
      d1   = satDec(mdl[t][1]);
      dsel = sel ? d1 : d0;
      expS = dead && (dsel != 0);
      if (!dead)        tag = "R10 plain slot";
      else if (s < NT)  tag = "R1 first deadline after reset";
      else if (t == 3)  tag = "R6 two timers";
      else if (t == 4)  tag = "R7 zero immediate";
      else if (t == 5)  tag = "R5 saturating count";
      else if (expS)    tag = "R3 replayed stall";
      else              tag = "R2 stall decision";
      expQ.push_back(expS);
      tagQ.push_back(tag);
      mdl[t][0] = d0;
      mdl[t][1] = d1;
      if (dead && !expS) mdl[t][sel] = imm;

      @(negedge clk); #1;
      act = slotStall;
      if (!dead) begin
        step[t] = (step[t] >= int'(cfgW[t])) ? 0 : step[t] + 1;
      end else if (!act) begin
        if (lastAcc[t][sel] >= 0 && (!cfgAlt[t] || sel == 1'b0)) begin
          int iters, k, rnd;
          longint expd;
          string ttag;
          iters = cfgAlt[t] ? 2 : 1;
          k     = iters * (int'(cfgW[t]) + 1);
          rnd   = (int'(imm) + NT - 1) / NT;
          expd  = NT * ((k > rnd) ? k : rnd);
          if (t == 4)      ttag = "R7 block length";
          else if (t == 5) ttag = "R5 block length";
          else if (t == 3) ttag = "R6 block length";
          else             ttag = "R8 R4 R9 block length";
          chk((s - lastAcc[t][sel]) == expd, ttag, s - lastAcc[t][sel], expd);
        end
        lastAcc[t][sel] = s;
        if (cfgAlt[t]) altPh[t] = ~altPh[t];
        step[t] = (step[t] >= int'(cfgW[t])) ? 0 : step[t] + 1;
      end
    end
  endtask

  // Monitor: compares the stall of each slot with the queued expectation.
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        bit e;
        string tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        chk(slotStall === e, tg, slotStall, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    summary();
  end

  initial begin
    resetAll();
    runPhase(600);
    resetAll();   // timers are busy here: R1 requires the clear
    runPhase(420);
    @(posedge clk);
    summary();
  end

endmodule